// File: doc/BRIEF.md
# Sample-Rate to Log-Pitch Converter

The block turns an unsigned 32-bit sample rate into a fixed-point base-2 logarithmic pitch word. The rate is first multiplied by a scale constant, and only the low 32 bits of the product are kept. A leading-one search then normalises the product. The bit position of the leading one, less a fixed bias, forms the integer part of the result, placed at bit 20 and above. The 20-bit fractional part comes from a 128-segment piecewise-linear approximation of log2: a base value for each segment, plus a per-segment slope multiplied by the next seven fraction bits.

Both segment tables are computed from their defining formulas when the design is elaborated. The result is registered one cycle after an input strobe. A downstream voice or oscillator setup path can present one rate per cycle.

Top module: `rate_log_pitch`

## Requirements
- R1: While reset is high, out_valid is 0 and out_pitch is 0 on the next clock edge.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high, so back-to-back inputs give back-to-back results; out_pitch holds the result for that input in the same cycle.
- R3: The converter works on P = (in_rate * 11185) mod 2^32; a rate of 48000 gives P = 0x20002380 and a pitch of exactly 0x00E00000.
- R4: A product P of 0 (in_rate = 0) gives a pitch of 0.
- R5: When the only set bit of P is bit 0, no leading one is found in bits 31..1 and the pitch is 0.
- R6: With i the highest set bit of P (1..31), the integer field is (i - 15) shifted left by 20, with all sums taken modulo 2^32; for P = 2 the pitch is 0xFF200000.
- R7: With N = P shifted left by 31-i, the segment index is N[30:24] and the base value is M(k) = round(2^20 * log2(1 + k/128)), so M(0) = 0 and M(127) = 0xFE8DF. For P = 0xFF000000 the pitch is 0x010FE8DF.
- R8: The interpolation term is N[23:17] times S(k) = ceil((M(k+1) - M(k)) / 128), taking M(128) = 2^20, so S(0) = 0x5C and S(127) = 0x2F. For P = 0x80FE0000 the pitch is 0x01002DA4; for P = 0xFFFE0000 it is 0x01100030.
- R9: In a cycle with in_valid low, out_pitch keeps its value whatever in_rate does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Rate strobe |
| in_rate | input | 32 | Unsigned sample rate |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_pitch | output | 32 | Log-pitch word: signed integer part at bits 31:20, fraction at bits 19:0 |

## Verification
The common audio rates 48000, 44100 and 8000 are compared with a reference model built from the log2 formula. The 48000 case is also pinned to its exact value, which confirms the scale factor and the bias without any table contribution. Rates chosen through the modular inverse of the scale constant set up exact products. These products reach the first and last table segments with zero and full fraction bits, so base and slope errors can be told apart. They also produce the products 1 and 2, which separate the no-leading-one case from the wrapped negative exponent. A long pseudo-random sweep with overflowing products, a back-to-back burst and an idle stretch with a changing rate cover the valid timing and the hold behaviour.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    localparam int unsigned RATE_W  = 32;
    localparam int unsigned POS_W   = $clog2(RATE_W);
    localparam int unsigned IDX_W   = 7;
    localparam int unsigned FRAC_W  = 7;
    localparam int unsigned MAG_W   = 20;
    localparam int unsigned SLOPE_W = 7;
    localparam int unsigned SEGS    = 1 << IDX_W;
    localparam int unsigned WIN_W   = IDX_W + FRAC_W;
    localparam int unsigned LOG_ITER = MAG_W + 8;

    typedef struct packed {
        logic               found;
        logic [POS_W-1:0]   pos;
        logic [IDX_W-1:0]   idx;
        logic [FRAC_W-1:0]  frac;
    } norm_t;

    // log2(1 + k/SEGS) in Q.MAG_W, rounded; k may equal SEGS (gives 2^MAG_W)
    function automatic logic [MAG_W:0] log_seg(input int k);
        logic [63:0]         x;
        logic [127:0]        sq;
        logic [LOG_ITER-1:0] r;
        logic [LOG_ITER:0]   rr;
        x = 64'(SEGS + k) << (60 - IDX_W);
        r = '0;
        for (int b = LOG_ITER - 1; b >= 0; b--) begin
            sq = {64'd0, x} * {64'd0, x};
            x  = 64'(sq >> 60);
            if (x >= (64'd2 << 60)) begin
                r[b] = 1'b1;
                x    = x >> 1;
            end
        end
        if (k >= int'(SEGS)) begin
            rr = (LOG_ITER+1)'(1) << LOG_ITER;
        end else begin
            rr = {1'b0, r} + (LOG_ITER+1)'(128);
        end
        return (MAG_W+1)'(rr >> 8);
    endfunction

    function automatic logic [MAG_W-1:0] mag_of(input int k);
        logic [MAG_W:0] v;
        v = log_seg(k);
        return v[MAG_W-1:0];
    endfunction

    function automatic logic [SLOPE_W-1:0] slope_of(input int k);
        logic [MAG_W:0] d;
        d = log_seg(k + 1) - log_seg(k);
        return SLOPE_W'((d + (MAG_W+1)'(127)) >> 7);
    endfunction

endpackage

// File: rtl/rlp_normalise.sv
module rlp_normalise
    import rlp_pkg::*;
(
    input  logic [RATE_W-1:0] prod,
    output norm_t             res
);
    logic [POS_W-1:0] shamt;
    logic [WIN_W-1:0] win;

    always_comb begin
        res = '0;
        for (int b = 1; b < int'(RATE_W); b++) begin
            if (prod[b]) begin
                res.found = 1'b1;
                res.pos   = POS_W'(b);
            end
        end
        shamt    = POS_W'(RATE_W - 1) - res.pos;
        win      = WIN_W'((prod << shamt) >> (RATE_W - 1 - WIN_W));
        res.idx  = win[WIN_W-1:FRAC_W];
        res.frac = win[FRAC_W-1:0];
    end
endmodule

// File: rtl/rlp_log_rom.sv
module rlp_log_rom
    import rlp_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [MAG_W-1:0]   mag,
    output logic [SLOPE_W-1:0] slope
);
    logic [MAG_W-1:0]   mag_tab   [SEGS];
    logic [SLOPE_W-1:0] slope_tab [SEGS];

    for (genvar g = 0; g < int'(SEGS); g++) begin : g_seg
        localparam logic [MAG_W-1:0]   SEG_MAG   = mag_of(g);
        localparam logic [SLOPE_W-1:0] SEG_SLOPE = slope_of(g);
        assign mag_tab[g]   = SEG_MAG;
        assign slope_tab[g] = SEG_SLOPE;
    end

    assign mag   = mag_tab[idx];
    assign slope = slope_tab[idx];
endmodule

// File: rtl/rlp_assemble.sv
module rlp_assemble
    import rlp_pkg::*;
#(
    parameter int unsigned BIAS = 15
) (
    input  norm_t              nrm,
    input  logic [MAG_W-1:0]   mag,
    input  logic [SLOPE_W-1:0] slope,
    output logic [RATE_W-1:0]  pitch
);
    logic [RATE_W-1:0]         expo;
    logic [FRAC_W+SLOPE_W-1:0] interp;

    always_comb begin
        expo   = (RATE_W'(nrm.pos) - RATE_W'(BIAS)) << MAG_W;
        interp = (FRAC_W+SLOPE_W)'(nrm.frac) * (FRAC_W+SLOPE_W)'(slope);
        if (nrm.found) begin
            pitch = expo + RATE_W'(mag) + RATE_W'(interp);
        end else begin
            pitch = '0;
        end
    end
endmodule

// File: rtl/rate_log_pitch.sv
module rate_log_pitch
    import rlp_pkg::*;
#(
    parameter int unsigned SCALE = 11185,
    parameter int unsigned BIAS  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_rate,
    output logic              out_valid,
    output logic [31:0]       out_pitch
);
    logic [RATE_W-1:0]  prod;
    norm_t              nrm;
    logic [MAG_W-1:0]   seg_mag;
    logic [SLOPE_W-1:0] seg_slope;
    logic [RATE_W-1:0]  pitch_c;

    assign prod = in_rate * RATE_W'(SCALE);

    rlp_normalise u_norm (
        .prod (prod),
        .res  (nrm)
    );

    rlp_log_rom u_rom (
        .idx   (nrm.idx),
        .mag   (seg_mag),
        .slope (seg_slope)
    );

    rlp_assemble #(.BIAS(BIAS)) u_asm (
        .nrm   (nrm),
        .mag   (seg_mag),
        .slope (seg_slope),
        .pitch (pitch_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pitch <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pitch <= pitch_c;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pitch == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pitch));

    a_r4_zero_rate: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_rate == '0) |=> out_pitch == '0);

    a_r5_no_lead_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !nrm.found) |=> out_pitch == '0);

    a_r6_exponent_field: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nrm.found && nrm.frac == '0) |=>
        out_pitch[RATE_W-1:MAG_W] == (RATE_W-MAG_W)'(32'($past(nrm.pos)) - BIAS));
endmodule

// File: tb/rate_log_pitch_test.sv
`timescale 1ns/1ps
module rate_log_pitch_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_rate = '0;
    logic        out_valid;
    logic [31:0] out_pitch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] inv_scale;

    always #10 clk = ~clk;

    rate_log_pitch uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_rate   (in_rate),
        .out_valid (out_valid),
        .out_pitch (out_pitch)
    );

    function automatic longint ref_mag(input int k);
        real v;
        if (k >= 128) return 64'd1048576;
        v = $ln(1.0 + k / 128.0) / $ln(2.0) * 1048576.0;
        return longint'($floor(v + 0.5));
    endfunction

    function automatic longint ref_slope(input int k);
        longint d;
        d = ref_mag(k + 1) - ref_mag(k);
        return (d + 127) / 128;
    endfunction

    function automatic logic [31:0] ref_pitch(input logic [31:0] r);
        logic [31:0] p, n, acc;
        int lead;
        p = r * 32'd11185;
        lead = -1;
        for (int b = 31; b >= 1; b--) begin
            if (p[b] && lead < 0) lead = b;
        end
        if (lead < 0) return 32'd0;
        n = p << (31 - lead);
        acc = (32'(lead) - 32'd15) << 20;
        acc = acc + 32'(ref_mag(int'(n[30:24])));
        acc = acc + 32'(n[23:17]) * 32'(ref_slope(int'(n[30:24])));
        return acc;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive one rate, return with output sampled at the following negedge
    task automatic send(input logic [31:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_rate  = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 pitch in reset", out_pitch, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_known_rates;
        send(32'd48000);
        chk("R2 valid 48000", 32'(out_valid), 32'd1);
        chk("R3 R6 pitch 48000", out_pitch, 32'h00E00000);
        send(32'd44100);
        chk("R7 R8 pitch 44100", out_pitch, ref_pitch(32'd44100));
        send(32'd8000);
        chk("R7 R8 pitch 8000", out_pitch, ref_pitch(32'd8000));
    endtask

    task automatic t_zero_and_tiny;
        send(32'd0);
        chk("R4 zero rate", out_pitch, 32'd0);
        send(32'd44100);
        send(inv_scale);
        chk("R5 product one", out_pitch, 32'd0);
        send(inv_scale * 32'd2);
        chk("R6 product two wraps", out_pitch, 32'hFF200000);
    endtask

    task automatic t_segment_ends;
        send(inv_scale * 32'hFF000000);
        chk("R7 last segment base", out_pitch, 32'h010FE8DF);
        send(inv_scale * 32'h80FE0000);
        chk("R8 first slope full frac", out_pitch, 32'h01002DA4);
        send(inv_scale * 32'hFFFE0000);
        chk("R8 last slope full frac", out_pitch, 32'h01100030);
        send(inv_scale * 32'h80000000);
        chk("R7 first segment base", out_pitch, 32'h01000000);
    endtask

    task automatic t_hold;
        logic [31:0] kept;
        send(32'd22050);
        kept = out_pitch;
        chk("R2 pitch 22050", kept, ref_pitch(32'd22050));
        for (int c = 0; c < 4; c++) begin
            in_rate = 32'h1234_0000 + 32'(c);
            @(negedge clk);
            chk("R2 valid idle low", 32'(out_valid), 32'd0);
            chk("R9 pitch held", out_pitch, kept);
        end
    endtask

    task automatic t_burst;
        logic [31:0] rates [4];
        rates[0] = 32'd11025; rates[1] = 32'd96000;
        rates[2] = 32'd1;     rates[3] = 32'd192000;
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            in_valid = 1'b1;
            in_rate  = rates[c];
            @(negedge clk);
            chk("R2 burst valid", 32'(out_valid), 32'd1);
            chk("R2 burst pitch", out_pitch, ref_pitch(rates[c]));
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 burst end", 32'(out_valid), 32'd0);
    endtask

    task automatic t_sweep;
        logic [31:0] r;
        r = 32'h2545F491;
        for (int c = 0; c < 300; c++) begin
            r = r * 32'd1664525 + 32'd1013904223;
            send((c % 2 == 0) ? (r >> (c % 17)) : r);
            chk("R3 R7 R8 sweep", out_pitch, ref_pitch(in_rate));
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        inv_scale = 32'd11185;
        for (int it = 0; it < 6; it++) begin
            inv_scale = inv_scale * (32'd2 - 32'd11185 * inv_scale);
        end
        t_reset();
        t_known_rates();
        t_zero_and_tiny();
        t_segment_ends();
        t_hold();
        t_burst();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule